// File: doc/BRIEF.md
# Network Utilization Bar-Graph Meter

This block measures how busy a 100 Mb/s shared medium is and shows the result on an eight-segment bar graph. It runs from a 25 MHz local clock, so one clock cycle carries one 4-bit nibble at line rate. It counts the cycles in which a receive-activity qualifier is high. At the end of each fixed sampling window it turns that count into a fraction of the full line rate and lights the display segments.

A full window is one second, which is 25,000,000 cycles. The window length is a parameter, and every segment threshold is derived from it, so a short window can be used in simulation. The steps are not evenly spaced: 1, 3, 5, 10, 20, 40, 60 and 80-or-more percent. The pattern is registered at each window boundary and held for the whole next window. A one-cycle strobe marks each boundary. A display enable blanks the segments without disturbing the measurement.

Top module: `util_bargraph_meter`

## Requirements
- R1: After reset, all eight segment outputs are low and the window strobe is low until the first window completes.
- R2: The window strobe `win_done` is high for exactly one cycle. It is first high in the cycle that follows the WINDOW_CYCLES-th clock edge after reset is released, and then once every WINDOW_CYCLES cycles.
- R3: The measured count of a window is the number of clock edges in that window at which `rx_active` is high. This includes the last edge of the window. The count starts from zero in each window, with nothing carried over from the previous one.
- R4: Segment bit i of `seg_led` is lit if and only if the count is at least floor(WINDOW_CYCLES*p/100). The percentage p is 1, 3, 5, 10, 20, 40, 60 and 80 for bits 0 through 7.
- R5: The display is a bar graph. Whenever bit i is lit, every bit below i is lit too, so the value of `seg_led` is always of the form 2^k-1.
- R6: The segment pattern changes only in the cycle the strobe is high, or when `disp_en` changes. Otherwise it stays the same for the whole window.
- R7: While `disp_en` is low, all segments are low. Counting goes on, and when `disp_en` returns high the held pattern of the last completed window appears.
- R8: A window with no activity lights no segment. A window that is active on every cycle lights all eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz local reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_active | input | 1 | High in cycles that carry received data |
| disp_en | input | 1 | Display enable; low blanks all segments |
| seg_led | output | 8 | Bar-graph segment levels, bit 0 is the lowest step |
| win_done | output | 1 | One-cycle strobe at each window boundary |

## Verification
The bench drives counts that sit exactly on each threshold and one below it. An off-by-one in the comparison or in the percentage scaling would light a step too early or too late. It places activity only in the last cycles of a window, so a design that drops the final edge's sample reads one step short. It also follows a saturated window with an idle one, which exposes a counter that does not clear. Blanking windows check that the enable hides the segments without stopping the count. Per-cycle comparison catches a pattern that moves inside a window or a strobe that lands off the window period.

// File: rtl/util_meter_pkg.sv
package util_meter_pkg;

  localparam int unsigned LEVELS = 8;

  // Percentage of the line rate at which each bar segment lights.
  function automatic int unsigned level_percent(input int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      2:       return 5;
      3:       return 10;
      4:       return 20;
      5:       return 40;
      6:       return 60;
      default: return 80;
    endcase
  endfunction

  // Busy-cycle count that a segment needs, rounded down.
  function automatic longint unsigned level_threshold(input longint unsigned window,
                                                      input int unsigned idx);
    return (window * longint'(level_percent(idx))) / 64'd100;
  endfunction

endpackage

// File: rtl/util_window_timer.sv
module util_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic win_end
);
  localparam int unsigned TW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

  logic [TW-1:0] tick_q;

  assign win_end = (tick_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)          tick_q <= '0;
    else if (win_end) tick_q <= '0;
    else              tick_q <= tick_q + 1'b1;
  end
endmodule

// File: rtl/util_busy_counter.sv
module util_busy_counter #(
  parameter int unsigned WINDOW_CYCLES = 25_000_000,
  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_active,
  input  logic          win_end,
  output logic [CW-1:0] busy_q,
  output logic [CW-1:0] tally
);
  // The tally includes this cycle's sample, so the last edge counts.
  assign tally = busy_q + CW'(rx_active);

  always_ff @(posedge clk) begin
    if (rst)          busy_q <= '0;
    else if (win_end) busy_q <= '0;
    else              busy_q <= tally;
  end
endmodule

// File: rtl/util_level_decoder.sv
module util_level_decoder #(
  parameter int unsigned WINDOW_CYCLES = 25_000_000,
  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1),
  localparam int unsigned NL = util_meter_pkg::LEVELS
) (
  input  logic [CW-1:0] tally,
  output logic [NL-1:0] pattern
);
  for (genvar i = 0; i < NL; i++) begin : g_step
    localparam logic [CW-1:0] THR =
      CW'(util_meter_pkg::level_threshold(64'(WINDOW_CYCLES), i));
    assign pattern[i] = (tally >= THR);
  end
endmodule

// File: rtl/util_display_latch.sv
module util_display_latch #(
  localparam int unsigned NL = util_meter_pkg::LEVELS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_end,
  input  logic          disp_en,
  input  logic [NL-1:0] pattern,
  output logic [NL-1:0] seg_led,
  output logic          win_done
);
  logic [NL-1:0] held_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= win_end;
      if (win_end) held_q <= pattern;
    end
  end

  assign seg_led  = disp_en ? held_q : '0;
  assign win_done = done_q;
endmodule

// File: rtl/util_bargraph_meter.sv
module util_bargraph_meter #(
  parameter int unsigned WINDOW_CYCLES = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_active,
  input  logic       disp_en,
  output logic [7:0] seg_led,
  output logic       win_done
);
  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1);

  logic          win_end;
  logic [CW-1:0] busy_q;
  logic [CW-1:0] tally;
  logic [7:0]    pattern;

  util_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .win_end(win_end)
  );

  util_busy_counter #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .rx_active(rx_active), .win_end(win_end),
    .busy_q(busy_q), .tally(tally)
  );

  util_level_decoder #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_dec (
    .tally(tally), .pattern(pattern)
  );

  util_display_latch u_disp (
    .clk(clk), .rst(rst), .win_end(win_end), .disp_en(disp_en),
    .pattern(pattern), .seg_led(seg_led), .win_done(win_done)
  );
endmodule

// File: rtl/util_meter_checker.sv
module util_meter_checker #(
  parameter int unsigned WINDOW_CYCLES = 25_000_000,
  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1),
  localparam int unsigned SW = $clog2(WINDOW_CYCLES + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_en,
  input logic [7:0]    seg_led,
  input logic          win_done,
  input logic          win_end,
  input logic [CW-1:0] busy_q,
  input logic [CW-1:0] tally
);
  logic [SW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      since_q <= win_done ? SW'(1) : since_q + 1'b1;
      if (win_done) seen_q <= 1'b1;
    end
  end

  AST_DARK_BEFORE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!seen_q && !win_done) |-> (seg_led == 8'h00)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    win_done |=> !win_done); // R2
  AST_DONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    win_done |-> (since_q == SW'(WINDOW_CYCLES))); // R2
  AST_DONE_NOT_LATE: assert property (@(posedge clk) disable iff (rst)
    since_q <= SW'(WINDOW_CYCLES)); // R2
  AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (busy_q == '0)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tally <= CW'(WINDOW_CYCLES)); // R3
  AST_BAR_SHAPE: assert property (@(posedge clk) disable iff (rst)
    ((seg_led & (seg_led + 8'd1)) == 8'h00)); // R5
  AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (!win_done && (disp_en == $past(disp_en))) |-> $stable(seg_led)); // R6
  AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !disp_en |-> (seg_led == 8'h00)); // R7
endmodule

bind util_bargraph_meter util_meter_checker #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .disp_en(disp_en), .seg_led(seg_led),
  .win_done(win_done), .win_end(win_end), .busy_q(busy_q), .tally(tally)
);

// File: tb/tb_util_bargraph_meter.sv
module tb_util_bargraph_meter;
  localparam int W = 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_active = 1'b0;
  logic       disp_en = 1'b1;
  logic [7:0] seg_led;
  logic       win_done;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  util_bargraph_meter #(.WINDOW_CYCLES(W)) dut (
    .clk(clk), .rst(rst), .rx_active(rx_active), .disp_en(disp_en),
    .seg_led(seg_led), .win_done(win_done)
  );

  function automatic int step_pct(input int i);
    int t[8] = '{1, 3, 5, 10, 20, 40, 60, 80};
    return t[i];
  endfunction

  function automatic logic [7:0] expect_bar(input int busy);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = (busy * 100 >= step_pct(i) * W);
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // mode 0: first n cycles busy; 1: spread evenly; 2: last n cycles busy
  task automatic drive_window(input int n, input int mode, input string tag,
                              input int en_on_at, input int en_off_at);
    exp_q.push_back(expect_bar(n));
    tag_q.push_back(tag);
    for (int k = 0; k < W; k++) begin
      case (mode)
        0:       rx_active = (k < n);
        1:       rx_active = ((k * n) / W) != (((k + 1) * n) / W);
        default: rx_active = (k >= W - n);
      endcase
      if (k == en_on_at)  disp_en = 1'b1;
      if (k == en_off_at) disp_en = 1'b0;
      @(negedge clk);
    end
  endtask

  // Monitor: scoreboard pop at each strobe, hold check on other cycles.
  initial begin
    logic [7:0] held = '0;
    logic [7:0] e;
    string      tg;
    bit         seen = 0;
    int         gap = 0;
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        gap = 0;
        check("R1", {seg_led[7:1], seg_led[0] | win_done}, 8'h00);
        continue;
      end
      gap++;
      if (win_done) begin
        n_chk++;
        if (gap != W) begin
          n_bad++;
          $display("FAIL R2: strobe after %0d cycles expected %0d", gap, W);
        end
        gap = 0;
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2: strobe with no window pending got 1 expected 0");
        end else begin
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          held = e;
          seen = 1;
          check(tg, seg_led, disp_en ? e : 8'h00);
          check("R5", seg_led & (seg_led + 8'd1), 8'h00);
        end
      end else begin
        if (!disp_en)  check("R7", seg_led, 8'h00);
        else if (!seen) check("R1", seg_led, 8'h00);
        else           check("R6", seg_led, held);
        n_chk++;
        if (gap > W) begin
          n_bad++;
          $display("FAIL R2: no strobe after %0d cycles expected %0d", gap, W);
        end
      end
    end
  end

  initial begin
    #(5ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung got running expected done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    drive_window(0,   0, "R8 idle", -1, -1);
    drive_window(W,   0, "R8 full", -1, -1);
    drive_window(0,   1, "R3 clear after full", -1, -1);
    drive_window(9,   0, "R4 below 1pct", -1, -1);
    drive_window(10,  2, "R3 last-edge at 1pct", -1, -1);
    drive_window(29,  1, "R4 below 3pct", -1, -1);
    drive_window(30,  1, "R4 at 3pct", -1, -1);
    drive_window(50,  0, "R4 at 5pct", -1, -1);
    drive_window(99,  2, "R4 below 10pct", -1, -1);
    drive_window(100, 1, "R4 at 10pct", -1, -1);
    drive_window(200, 0, "R4 at 20pct", -1, -1);
    drive_window(399, 1, "R4 below 40pct", -1, -1);
    drive_window(400, 2, "R4 at 40pct", -1, -1);
    drive_window(600, 1, "R4 at 60pct", -1, -1);
    drive_window(799, 0, "R4 below 80pct", -1, -1);
    drive_window(800, 1, "R5 at 80pct", -1, -1);
    drive_window(500, 1, "R7 blank mid window", -1, 300);
    drive_window(250, 0, "R7 count while blank", 400, -1);
    drive_window(0,   0, "R3 idle after blank", -1, -1);
    repeat (3) @(negedge clk);
    check("R2 queue drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule